// File: doc/BRIEF.md
# Network Interface Host Register File

This block is the register space a host processor sees on a network interface board. A single word-addressed request port selects one of six regions: a page-map table that the host fills with 16-bit translation entries, a small identification PROM whose contents are fixed when the design is built, a control/status word, a reserved word, a parity control word and a parity error address word. All registers are 16-bit words. A read returns its data on the clock edge that accepts the request.

The control/status word drives the network controller directly. Its top three bits give the controller reset, channel attention and an active-low loopback control. It carries an interrupt enable that gates the controller's interrupt onto the host interrupt line. Several of its bits are status that the host cannot alter. These are the interrupt pending flag, a sticky parity error flag, a large-RAM flag that is always set, and a four-bit nibble holding address bits 19..16 of the board memory port base, set by parameter.

Top module: `nic_host_regs`

## Requirements
- R1: Word addresses 0 to PMAP_WORDS-1 form the page map; each entry stores and reads back all 16 bits written.
- R2: The next PROM_WORDS word addresses read the PROM image, where word i is PROM_IMAGE[16*i+15:16*i]; writes there change nothing.
- R3: Control/status word (word address PMAP_WORDS+PROM_WORDS): only bits 15, 14, 13, 12, 11 and 5 take write data; bits 10, 7 and 6 read 0 and the other bits keep their status values on a write.
- R4: After reset the control/status word reads 0x4010 with bits [3:0] equal to MEM_BASE[19:16], whose low 16 bits are zero.
- R5: ctrl_reset equals control/status bit 15, ctrl_attn equals bit 13, and ctrl_loop equals the inverse of bit 14, all changing on the edge that accepts the write.
- R6: Status bit 8 takes irq_in at every clock edge; host_irq is high exactly when bit 8 and enable bit 12 are both set.
- R7: Status bit 9 is set by parity_err_in and stays set until a parity control write with data bit 8 set; if both happen on one edge the flag stays set.
- R8: Parity control word (next word after the reserved one): only bit 8 is writable; the other bits read 0 and reset is 0x0000.
- R9: The parity error address word (last word) is a 16-bit read/write register reset to 0; the reserved word and any address past the map read 0 and ignore writes.
- R10: rd_data is registered and changes only on a read request, showing the value the addressed word held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request accepted on this edge |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | AW (11) | Word address |
| req_wdata | input | 16 | Write data |
| rd_data | output | 16 | Read data, one edge after the read request |
| irq_in | input | 1 | Interrupt from the network controller |
| parity_err_in | input | 1 | Parity error strobe |
| ctrl_reset | output | 1 | Reset to the controller |
| ctrl_loop | output | 1 | Loopback to the controller |
| ctrl_attn | output | 1 | Channel attention to the controller |
| host_irq | output | 1 | Interrupt request to the host |

## Verification
Every result of this block is due one clock edge after its cause. Read data, the control outputs after a control/status write, the pending flag after irq_in and the parity flag after its strobe all update on that edge. The bench drives each stimulus on a falling edge, lets exactly one rising edge pass, and samples on the following falling edge, so each check lands in the first cycle where the new value must be visible. The hold and ignore checks sample in that same cycle after a write, before any other request.

// File: rtl/nhr_pkg.sv
// Shared types and field positions for the host register file.
// Assumes 16-bit registers; the bit positions below are decoded by the controller pins.
package nhr_pkg;

    typedef enum logic [2:0] {
        RG_PMAP  = 3'd0,
        RG_PROM  = 3'd1,
        RG_CSR   = 3'd2,
        RG_HOLE  = 3'd3,
        RG_PCR   = 3'd4,
        RG_PADDR = 3'd5,
        RG_NONE  = 3'd6
    } region_e;

    localparam int DW = 16;

    // control/status bit positions
    localparam int CS_RESET  = 15;
    localparam int CS_NOLOOP = 14;
    localparam int CS_ATTN   = 13;
    localparam int CS_IE     = 12;
    localparam int CS_PERR   = 9;
    localparam int CS_PEND   = 8;
    localparam int CS_BIGRAM = 4;

    // bits the host may write in the control/status word
    localparam logic [DW-1:0] CS_WMASK = 16'hF820;
    localparam logic [DW-1:0] CS_RESET_VAL = 16'h4000;

    // parity control acknowledge bit
    localparam int PC_ACK = 8;

endpackage

// File: rtl/nhr_decode.sv
// Word-address decoder: maps an address onto a region and region-local indices.
// Assumes region order page map, PROM, control/status, reserved, parity control, error address.
module nhr_decode
    import nhr_pkg::*;
#(
    parameter int PMAP_WORDS = 1024,
    parameter int PROM_WORDS = 32,
    parameter int AW  = 11,
    parameter int PMW = 10,
    parameter int PRW = 5
) (
    input  logic [AW-1:0]  addr,
    output region_e        region,
    output logic [PMW-1:0] pm_idx,
    output logic [PRW-1:0] prom_idx
);
    localparam logic [AW-1:0] PROM_LO = AW'(PMAP_WORDS);
    localparam logic [AW-1:0] CSR_A   = AW'(PMAP_WORDS + PROM_WORDS);
    localparam logic [AW-1:0] HOLE_A  = CSR_A + AW'(1);
    localparam logic [AW-1:0] PCR_A   = CSR_A + AW'(2);
    localparam logic [AW-1:0] PADDR_A = CSR_A + AW'(3);

    logic [AW-1:0] prom_off;

    // region select by address range
    always_comb begin
        prom_off = addr - PROM_LO;
        pm_idx   = addr[PMW-1:0];
        prom_idx = prom_off[PRW-1:0];
        if (addr < PROM_LO)      region = RG_PMAP;
        else if (addr < CSR_A)   region = RG_PROM;
        else if (addr == CSR_A)  region = RG_CSR;
        else if (addr == HOLE_A) region = RG_HOLE;
        else if (addr == PCR_A)  region = RG_PCR;
        else if (addr == PADDR_A) region = RG_PADDR;
        else                     region = RG_NONE;
    end
endmodule

// File: rtl/nhr_pagemap.sv
// Page-map storage: one write or read per cycle, registered read data.
// Assumes read data must hold between reads, so the output register loads only on re.
module nhr_pagemap
    import nhr_pkg::*;
#(
    parameter int WORDS = 1024,
    parameter int IW    = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          re,
    input  logic [IW-1:0] idx,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [WORDS];

    // table write port
    always_ff @(posedge clk) begin
        if (we) mem[idx] <= wdata;
    end

    // registered read, old value on a same-edge update
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (re) rdata <= mem[idx];
    end
endmodule

// File: rtl/nhr_ctrl.sv
// Control/status, parity control and error address registers.
// Assumes status bits come only from irq_in, parity_err_in and the base nibble parameter.
module nhr_ctrl
    import nhr_pkg::*;
#(
    parameter logic [3:0] BASE_NIB = 4'h3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_csr,
    input  logic          wr_pcr,
    input  logic          wr_paddr,
    input  logic [DW-1:0] wdata,
    input  logic          irq_in,
    input  logic          parity_err_in,
    output logic [DW-1:0] csr,
    output logic [DW-1:0] pcr,
    output logic [DW-1:0] paddr
);
    logic [DW-1:0] host_bits;
    logic          pend_q;
    logic          perr_q;
    logic          ack_q;

    // host-writable control/status bits
    always_ff @(posedge clk) begin
        if (!rst_n)      host_bits <= CS_RESET_VAL;
        else if (wr_csr) host_bits <= wdata & CS_WMASK;
    end

    // pending flag samples the controller interrupt
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= irq_in;
    end

    // sticky parity flag, a new error beats an acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n)                       perr_q <= 1'b0;
        else if (parity_err_in)           perr_q <= 1'b1;
        else if (wr_pcr && wdata[PC_ACK]) perr_q <= 1'b0;
    end

    // parity acknowledge bit and error address word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q <= 1'b0;
            paddr <= '0;
        end else begin
            if (wr_pcr)   ack_q <= wdata[PC_ACK];
            if (wr_paddr) paddr <= wdata;
        end
    end

    // assemble the readable words
    always_comb begin
        csr = host_bits;
        csr[CS_PERR]   = perr_q;
        csr[CS_PEND]   = pend_q;
        csr[CS_BIGRAM] = 1'b1;
        csr[3:0]       = BASE_NIB;
        pcr = '0;
        pcr[PC_ACK] = ack_q;
    end
endmodule

// File: rtl/nic_host_regs.sv
// Top of the host register file: decode, read path and controller outputs.
// Assumes one request per cycle and MEM_BASE with its low 16 bits zero.
module nic_host_regs
    import nhr_pkg::*;
#(
    parameter int PMAP_WORDS = 1024,
    parameter int PROM_WORDS = 32,
    parameter logic [19:0] MEM_BASE = 20'h30000,
    parameter logic [PROM_WORDS*16-1:0] PROM_IMAGE = '0,
    localparam int AW = $clog2(PMAP_WORDS + PROM_WORDS + 4)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [15:0]   req_wdata,
    output logic [15:0]   rd_data,
    input  logic          irq_in,
    input  logic          parity_err_in,
    output logic          ctrl_reset,
    output logic          ctrl_loop,
    output logic          ctrl_attn,
    output logic          host_irq
);
    localparam int PMW = (PMAP_WORDS > 1) ? $clog2(PMAP_WORDS) : 1;
    localparam int PRW = (PROM_WORDS > 1) ? $clog2(PROM_WORDS) : 1;
    localparam logic [3:0] BASE_NIB = MEM_BASE[19:16];

    region_e        region;
    logic [PMW-1:0] pm_idx;
    logic [PRW-1:0] prom_idx;
    logic           wr_op, rd_op;
    logic [DW-1:0]  csr, pcr, paddr, pm_rdata, local_val, local_q;
    logic           from_pm_q;

    assign wr_op = req_valid &&  req_write;
    assign rd_op = req_valid && !req_write;

    nhr_decode #(
        .PMAP_WORDS(PMAP_WORDS), .PROM_WORDS(PROM_WORDS),
        .AW(AW), .PMW(PMW), .PRW(PRW)
    ) u_dec (
        .addr(req_addr), .region(region), .pm_idx(pm_idx), .prom_idx(prom_idx)
    );

    nhr_pagemap #(.WORDS(PMAP_WORDS), .IW(PMW)) u_pmap (
        .clk(clk), .rst_n(rst_n),
        .we(wr_op && region == RG_PMAP),
        .re(rd_op && region == RG_PMAP),
        .idx(pm_idx), .wdata(req_wdata), .rdata(pm_rdata)
    );

    nhr_ctrl #(.BASE_NIB(BASE_NIB)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .wr_csr(wr_op && region == RG_CSR),
        .wr_pcr(wr_op && region == RG_PCR),
        .wr_paddr(wr_op && region == RG_PADDR),
        .wdata(req_wdata), .irq_in(irq_in), .parity_err_in(parity_err_in),
        .csr(csr), .pcr(pcr), .paddr(paddr)
    );

    // value of the addressed non-table word
    always_comb begin
        case (region)
            RG_PROM:  local_val = PROM_IMAGE[{prom_idx, 4'b0000} +: 16];
            RG_CSR:   local_val = csr;
            RG_PCR:   local_val = pcr;
            RG_PADDR: local_val = paddr;
            default:  local_val = '0;
        endcase
    end

    // read stage, loaded only by read requests
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            from_pm_q <= 1'b0;
            local_q   <= '0;
        end else if (rd_op) begin
            from_pm_q <= (region == RG_PMAP);
            local_q   <= local_val;
        end
    end

    assign rd_data    = from_pm_q ? pm_rdata : local_q;
    assign ctrl_reset = csr[CS_RESET];
    assign ctrl_loop  = ~csr[CS_NOLOOP];
    assign ctrl_attn  = csr[CS_ATTN];
    assign host_irq   = csr[CS_IE] & csr[CS_PEND];
endmodule

// File: rtl/nhr_checker.sv
// Assertion checker for the host register file, bound to the top module.
// Assumes the same parameters as the top and sees its control/status word.
module nhr_checker
    import nhr_pkg::*;
#(
    parameter int AW = 11,
    parameter int CSR_A = 1056,
    parameter logic [3:0] BASE_NIB = 4'h3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_write,
    input logic [AW-1:0] req_addr,
    input logic [15:0]   req_wdata,
    input logic [15:0]   rd_data,
    input logic          irq_in,
    input logic          parity_err_in,
    input logic          ctrl_reset,
    input logic          ctrl_loop,
    input logic          ctrl_attn,
    input logic          host_irq,
    input logic [15:0]   csr
);
    localparam logic [AW-1:0] CA = AW'(CSR_A);
    localparam logic [AW-1:0] HA = AW'(CSR_A + 1);

    logic csr_wr, csr_rd, hole_rd;
    assign csr_wr  = req_valid &&  req_write && req_addr == CA;
    assign csr_rd  = req_valid && !req_write && req_addr == CA;
    assign hole_rd = req_valid && !req_write && req_addr == HA;

    p_wmask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        csr_wr |=> ((csr & CS_WMASK) == ($past(req_wdata) & CS_WMASK)));

    p_nibble_r4: assert property (@(posedge clk) disable iff (!rst_n)
        csr_rd |=> (rd_data[4:0] == {1'b1, BASE_NIB}));

    p_loop_inv_r5: assert property (@(posedge clk) disable iff (!rst_n)
        csr_wr |=> (ctrl_loop == !$past(req_wdata[CS_NOLOOP])));

    p_rst_attn_r5: assert property (@(posedge clk) disable iff (!rst_n)
        csr_wr |=> (ctrl_reset == $past(req_wdata[CS_RESET])
                    && ctrl_attn == $past(req_wdata[CS_ATTN])));

    p_irq_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |-> $past(irq_in));

    p_perr_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        parity_err_in |=> csr[CS_PERR]);

    p_hole_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hole_rd |=> (rd_data == 16'h0000));

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> $stable(rd_data));
endmodule

bind nic_host_regs nhr_checker #(
    .AW(AW), .CSR_A(PMAP_WORDS + PROM_WORDS), .BASE_NIB(MEM_BASE[19:16])
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
    .irq_in(irq_in), .parity_err_in(parity_err_in), .ctrl_reset(ctrl_reset),
    .ctrl_loop(ctrl_loop), .ctrl_attn(ctrl_attn), .host_irq(host_irq), .csr(csr)
);

// File: tb/nic_host_regs_tb.sv
module nic_host_regs_tb;
    localparam int AW = 11;
    localparam logic [10:0] A_CSR = 11'h420, A_HOLE = 11'h421, A_PCR = 11'h422, A_PADDR = 11'h423;

    function automatic logic [511:0] mk_prom();
        logic [511:0] img;
        for (int i = 0; i < 32; i++) img[i*16 +: 16] = 16'hC000 | 16'(i * 16'h0101);
        return img;
    endfunction
    localparam logic [511:0] PROM_IMG = mk_prom();

    logic clk = 0, rst_n = 0;
    logic req_valid = 0, req_write = 0;
    logic [AW-1:0] req_addr = '0;
    logic [15:0] req_wdata = '0, rd_data;
    logic irq_in = 0, parity_err_in = 0;
    logic ctrl_reset, ctrl_loop, ctrl_attn, host_irq;
    int checks = 0, errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    nic_host_regs #(.MEM_BASE(20'hA0000), .PROM_IMAGE(PROM_IMG)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
        .irq_in(irq_in), .parity_err_in(parity_err_in), .ctrl_reset(ctrl_reset),
        .ctrl_loop(ctrl_loop), .ctrl_attn(ctrl_attn), .host_irq(host_irq)
    );

    // {op, addr, wdata, expected}: op 1 write, 2 read and compare
    localparam int NV = 21;
    localparam logic [44:0] VEC [NV] = '{
        {2'd1, 11'h000, 16'h1234, 16'h0000},   // R1
        {2'd1, 11'h3FF, 16'hBEEF, 16'h0000},
        {2'd2, 11'h000, 16'h0000, 16'h1234},
        {2'd2, 11'h3FF, 16'h0000, 16'hBEEF},
        {2'd1, 11'h405, 16'hFFFF, 16'h0000},   // R2
        {2'd2, 11'h405, 16'h0000, 16'hC505},
        {2'd2, 11'h41F, 16'h0000, 16'hDF1F},
        {2'd1, A_CSR,   16'hFFFF, 16'h0000},   // R3
        {2'd2, A_CSR,   16'h0000, 16'hF83A},
        {2'd1, A_CSR,   16'h0000, 16'h0000},
        {2'd2, A_CSR,   16'h0000, 16'h001A},
        {2'd1, A_PCR,   16'hFFFF, 16'h0000},   // R8
        {2'd2, A_PCR,   16'h0000, 16'h0100},
        {2'd1, A_PADDR, 16'h5A5A, 16'h0000},   // R9
        {2'd2, A_PADDR, 16'h0000, 16'h5A5A},
        {2'd1, A_HOLE,  16'hFFFF, 16'h0000},
        {2'd2, A_HOLE,  16'h0000, 16'h0000},
        {2'd2, 11'h7FF, 16'h0000, 16'h0000},
        {2'd1, A_CSR,   16'h4000, 16'h0000},
        {2'd2, A_CSR,   16'h0000, 16'h401A},
        {2'd2, 11'h000, 16'h0000, 16'h1234}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // one request, one rising edge, return on the following falling edge
    task automatic op(input logic wr, input logic [10:0] a, input logic [15:0] d);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 0; req_write = 0;
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // reset state
        chk("R5 reset out", {12'b0, ctrl_reset, ctrl_loop, ctrl_attn, host_irq}, 16'h0);
        op(0, A_CSR, 0);   chk("R4 csr reset", rd_data, 16'h401A);
        op(0, A_PCR, 0);   chk("R8 pcr reset", rd_data, 16'h0000);
        op(0, A_PADDR, 0); chk("R9 paddr reset", rd_data, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            op(VEC[i][43], VEC[i][42:32], VEC[i][31:16]);
            if (VEC[i][44:43] == 2'd2)
                chk($sformatf("R1-map vec%0d", i), rd_data, VEC[i][15:0]);
        end

        // R10: data held across a write
        op(0, 11'h405, 0);
        op(1, A_PADDR, 16'h0001); chk("R10 hold", rd_data, 16'hC505);

        // R5: controller outputs on the write edge
        op(1, A_CSR, 16'hA000);
        chk("R5 outputs set", {13'b0, ctrl_reset, ctrl_loop, ctrl_attn}, 16'h0007);
        op(1, A_CSR, 16'h4000);
        chk("R5 outputs clear", {13'b0, ctrl_reset, ctrl_loop, ctrl_attn}, 16'h0000);

        // R6: gated interrupt
        op(1, A_CSR, 16'h5000);
        irq_in = 1; @(negedge clk);
        chk("R6 irq on", {15'b0, host_irq}, 16'h1);
        op(0, A_CSR, 0); chk("R6 pending bit", rd_data, 16'h511A);
        irq_in = 0; @(negedge clk);
        chk("R6 irq off", {15'b0, host_irq}, 16'h0);
        op(1, A_CSR, 16'h4000);
        irq_in = 1; @(negedge clk);
        chk("R6 irq masked", {15'b0, host_irq}, 16'h0);
        irq_in = 0; @(negedge clk);

        // R7: sticky parity flag
        parity_err_in = 1; @(negedge clk); parity_err_in = 0;
        op(0, A_CSR, 0); chk("R7 set", rd_data, 16'h421A);
        op(1, A_PCR, 16'h0000);
        op(0, A_CSR, 0); chk("R7 no ack", rd_data, 16'h421A);
        op(1, A_PCR, 16'h0100);
        op(0, A_CSR, 0); chk("R7 ack", rd_data, 16'h401A);
        parity_err_in = 1; op(1, A_PCR, 16'h0100); parity_err_in = 0;
        op(0, A_CSR, 0); chk("R7 set wins", rd_data, 16'h421A);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule